// File: doc/BRIEF.md
# Three-Channel Rounding Normalization Divider

This block turns accumulated colour sums into output pixels. Each cycle it may take one numerator per colour channel (red, green, blue) together with a single divisor shared by all three, which is the number of contributions that fed that output pixel. It divides each numerator by the shared divisor and rounds the quotient to the nearest integer using the remainder. The result is then clamped to the pixel width, so the output has the same type as the original input pixels.

The divider is fully pipelined and has no stall. A new operand set can enter on every clock, and each result appears a fixed nine cycles later with an aligned valid flag. It is meant to be fed by a memory dump sequencer that walks the accumulated frame one pixel per cycle. A divisor of zero marks a pixel that no sample reached, and it produces a black pixel.

Top module: `rgb_norm_divider`

## Requirements
- R1: For a divisor D >= 1 and numerator N, each output pixel equals floor(N/D) + 1 when 2*(N mod D) >= D, and floor(N/D) otherwise (before the clamp of R6).
- R2: Operands sampled with `in_valid` high at clock edge E appear on the pixel outputs, with `out_valid` high, directly after edge E+8. That is nine register stages. `out_valid` is high only for such results.
- R3: Operand sets presented on consecutive cycles give results on consecutive cycles, in the same order. No input can stall or drop a result.
- R4: The three channels are divided by the same divisor taken in the same cycle. Each channel's result depends only on its own numerator.
- R5: A divisor of 0 gives 0 on all three pixel outputs for that result, with no other indication.
- R6: A rounded value above 2^PIX_W - 1 (255 by default) is output as 2^PIX_W - 1.
- R7: While `rst_n` is low, `out_valid` and all pixel outputs are 0. Operands that entered before the reset never produce an `out_valid` pulse.
- R8: In a cycle with no new result, the pixel outputs keep the last result.
- R9: An exact half (2*(N mod D) == D) rounds up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present this cycle |
| num_r | input | NUM_W | Red channel numerator |
| num_g | input | NUM_W | Green channel numerator |
| num_b | input | NUM_W | Blue channel numerator |
| den | input | DEN_W | Shared divisor (contribution count) |
| out_valid | output | 1 | Result present on pixel outputs |
| pix_r | output | PIX_W | Rounded red pixel |
| pix_g | output | PIX_W | Rounded green pixel |
| pix_b | output | PIX_W | Rounded blue pixel |

## Verification
The round-up of R1 and the clamp of R6 can act on the same result. This happens when the quotient is exactly the pixel maximum and the remainder is at least half the divisor, or when the quotient itself is already out of range. Vectors such as 511/2 (255.5, rounds to 256 and is clamped to 255), 65534/255 and 65535/3 provoke this case. The bench checks that the clamped maximum comes out, not a wrapped value. These vectors run back to back with exact-half, zero-divisor and in-range vectors, so results from different paths leave the pipeline in adjacent cycles. Each result is compared against floor-plus-round values computed by hand.

// File: rtl/rgb_norm_pkg.sv
package rgb_norm_pkg;
  // Register stages from operand capture to pixel outputs.
  localparam int unsigned RN_LATENCY    = 9;
  // Division stages; the last stage rounds and clamps.
  localparam int unsigned RN_DIV_STAGES = RN_LATENCY - 1;
  // Colour channels sharing one divisor.
  localparam int unsigned RN_CHANNELS   = 3;
endpackage

// File: rtl/rgb_norm_stage.sv
// One registered slice of a restoring divider for a single channel.
// nq holds the numerator bits still to be consumed in its upper part
// and the quotient bits already produced in its lower part.
module rgb_norm_stage #(
  parameter int unsigned NQ_W  = 16,
  parameter int unsigned DEN_W = 8,
  parameter int unsigned STEPS = 2
) (
  input  logic             clk,
  input  logic [DEN_W-1:0] in_rem,
  input  logic [NQ_W-1:0]  in_nq,
  input  logic [DEN_W-1:0] in_den,
  output logic [DEN_W-1:0] out_rem,
  output logic [NQ_W-1:0]  out_nq
);

  // Returns {quotient bit, new partial remainder}.
  function automatic logic [DEN_W:0] div_bit(
    input logic [DEN_W-1:0] r,
    input logic             b,
    input logic [DEN_W-1:0] d
  );
    logic [DEN_W:0] sh;
    logic [DEN_W:0] df;
    sh = {r, b};
    df = sh - {1'b0, d};
    if (sh >= {1'b0, d}) return {1'b1, df[DEN_W-1:0]};
    return {1'b0, sh[DEN_W-1:0]};
  endfunction

  logic [DEN_W-1:0] nxt_rem;
  logic [NQ_W-1:0]  nxt_nq;

  always_comb begin
    logic [DEN_W-1:0] r;
    logic [NQ_W-1:0]  nq;
    logic [DEN_W:0]   st;
    r  = in_rem;
    nq = in_nq;
    for (int s = 0; s < STEPS; s++) begin
      st = div_bit(r, nq[NQ_W-1], in_den);
      r  = st[DEN_W-1:0];
      nq = {nq[NQ_W-2:0], st[DEN_W]};
    end
    nxt_rem = r;
    nxt_nq  = nq;
  end

  always_ff @(posedge clk) begin
    out_rem <= nxt_rem;
    out_nq  <= nxt_nq;
  end

endmodule

// File: rtl/rgb_norm_round.sv
// Final stage: round-to-nearest from the remainder, zero-divisor
// override, clamp to the pixel range, hold when no result arrives.
module rgb_norm_round #(
  parameter int unsigned QW    = 16,
  parameter int unsigned DEN_W = 8,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [QW-1:0]    quo,
  input  logic [DEN_W-1:0] rem,
  input  logic [DEN_W-1:0] den,
  output logic [PIX_W-1:0] pix
);

  localparam logic [QW:0] PIX_TOP = {{(QW + 1 - PIX_W){1'b0}}, {PIX_W{1'b1}}};

  function automatic logic [PIX_W-1:0] round_pix(
    input logic [QW-1:0]    q,
    input logic [DEN_W-1:0] r,
    input logic [DEN_W-1:0] d
  );
    logic [QW:0] sum;
    logic        up;
    if (d == '0) return '0;
    up  = ({r, 1'b0} >= {1'b0, d});
    sum = {1'b0, q} + {{QW{1'b0}}, up};
    if (sum > PIX_TOP) return '1;
    return sum[PIX_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pix <= '0;
    else if (en) pix <= round_pix(quo, rem, den);
  end

endmodule

// File: rtl/rgb_norm_divider.sv
module rgb_norm_divider
  import rgb_norm_pkg::*;
#(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 8,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NUM_W-1:0] num_r,
  input  logic [NUM_W-1:0] num_g,
  input  logic [NUM_W-1:0] num_b,
  input  logic [DEN_W-1:0] den,
  output logic             out_valid,
  output logic [PIX_W-1:0] pix_r,
  output logic [PIX_W-1:0] pix_g,
  output logic [PIX_W-1:0] pix_b
);

  localparam int unsigned STEPS = (NUM_W + RN_DIV_STAGES - 1) / RN_DIV_STAGES;
  localparam int unsigned NQ_W  = STEPS * RN_DIV_STAGES;

  logic [RN_CHANNELS-1:0][NQ_W-1:0]                   nq_in;
  logic [RN_DIV_STAGES:1][RN_CHANNELS-1:0][NQ_W-1:0]  nq_s;
  logic [RN_DIV_STAGES:1][RN_CHANNELS-1:0][DEN_W-1:0] rem_s;
  logic [RN_DIV_STAGES:1][DEN_W-1:0]                  den_s;
  logic [RN_DIV_STAGES:1]                             vld_s;
  logic [RN_CHANNELS-1:0][PIX_W-1:0]                  pix_v;

  assign nq_in[0] = NQ_W'(num_r);
  assign nq_in[1] = NQ_W'(num_g);
  assign nq_in[2] = NQ_W'(num_b);

  // Shared divisor travels alongside the partial results.
  always_ff @(posedge clk) begin
    den_s[1] <= den;
    for (int s = 2; s <= RN_DIV_STAGES; s++) den_s[s] <= den_s[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s     <= '0;
      out_valid <= 1'b0;
    end else begin
      vld_s[1] <= in_valid;
      for (int s = 2; s <= RN_DIV_STAGES; s++) vld_s[s] <= vld_s[s-1];
      out_valid <= vld_s[RN_DIV_STAGES];
    end
  end

  for (genvar s = 1; s <= RN_DIV_STAGES; s++) begin : g_stage
    for (genvar c = 0; c < RN_CHANNELS; c++) begin : g_ch
      logic [DEN_W-1:0] rem_i;
      logic [DEN_W-1:0] den_i;
      logic [NQ_W-1:0]  nq_i;
      if (s == 1) begin : g_first
        assign rem_i = '0;
        assign nq_i  = nq_in[c];
        assign den_i = den;
      end else begin : g_next
        assign rem_i = rem_s[s-1][c];
        assign nq_i  = nq_s[s-1][c];
        assign den_i = den_s[s-1];
      end
      rgb_norm_stage #(
        .NQ_W (NQ_W),
        .DEN_W(DEN_W),
        .STEPS(STEPS)
      ) u_stage (
        .clk    (clk),
        .in_rem (rem_i),
        .in_nq  (nq_i),
        .in_den (den_i),
        .out_rem(rem_s[s][c]),
        .out_nq (nq_s[s][c])
      );
    end
  end

  for (genvar c = 0; c < RN_CHANNELS; c++) begin : g_round
    rgb_norm_round #(
      .QW   (NQ_W),
      .DEN_W(DEN_W),
      .PIX_W(PIX_W)
    ) u_round (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (vld_s[RN_DIV_STAGES]),
      .quo  (nq_s[RN_DIV_STAGES][c]),
      .rem  (rem_s[RN_DIV_STAGES][c]),
      .den  (den_s[RN_DIV_STAGES]),
      .pix  (pix_v[c])
    );
  end

  assign pix_r = pix_v[0];
  assign pix_g = pix_v[1];
  assign pix_b = pix_v[2];

endmodule

// File: rtl/rgb_norm_divider_chk.sv
module rgb_norm_divider_chk #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 8,
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NUM_W-1:0] num_r,
  input logic [NUM_W-1:0] num_g,
  input logic [NUM_W-1:0] num_b,
  input logic [DEN_W-1:0] den,
  input logic             out_valid,
  input logic [PIX_W-1:0] pix_r,
  input logic [PIX_W-1:0] pix_g,
  input logic [PIX_W-1:0] pix_b
);

  // Cycles since reset release, saturating; guards every $past below.
  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  logic hist_ok;
  assign hist_ok = (since_rst >= 4'd9);

  // R2: valid emerges exactly nine edges after capture.
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> (out_valid == $past(in_valid, 9)));

  // R5: empty pixel gives black on every channel.
  p_zero_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && out_valid && $past(den, 9) == '0) |->
      (pix_r == '0 && pix_g == '0 && pix_b == '0));

  // R1: a rounded quotient never exceeds its numerator.
  p_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && out_valid && $past(den, 9) != '0) |->
      (NUM_W'(pix_r) <= $past(num_r, 9) && NUM_W'(pix_g) <= $past(num_g, 9) &&
       NUM_W'(pix_b) <= $past(num_b, 9)));

  // R6: unit divisor with a numerator out of range clamps to the top.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && out_valid && $past(den, 9) == DEN_W'(1) &&
     $past(num_r, 9) > NUM_W'((1 << PIX_W) - 1)) |-> (pix_r == '1));

  // R8: pixels hold in cycles that bring no result.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd1 && !out_valid) |->
      ($stable(pix_r) && $stable(pix_g) && $stable(pix_b)));

endmodule

bind rgb_norm_divider rgb_norm_divider_chk #(
  .NUM_W(NUM_W),
  .DEN_W(DEN_W),
  .PIX_W(PIX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .num_r    (num_r),
  .num_g    (num_g),
  .num_b    (num_b),
  .den      (den),
  .out_valid(out_valid),
  .pix_r    (pix_r),
  .pix_g    (pix_g),
  .pix_b    (pix_b)
);

// File: tb/rgb_norm_divider_bench.sv
`timescale 1ns/1ps
module rgb_norm_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] num_r, num_g, num_b;
  logic [7:0]  den;
  logic        out_valid;
  logic [7:0]  pix_r, pix_g, pix_b;

  always #2 clk = ~clk;

  rgb_norm_divider u_rgb_norm_divider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .num_r(num_r), .num_g(num_g), .num_b(num_b), .den(den),
    .out_valid(out_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected-result queue filled by push, drained by the monitor.
  logic [7:0] exp_r [0:63];
  logic [7:0] exp_g [0:63];
  logic [7:0] exp_b [0:63];
  int         stamp [0:63];
  string      tag   [0:63];
  int wr = 0;
  int rd = 0;

  // {num_r, num_g, num_b, den, exp_r, exp_g, exp_b}, worked by hand.
  localparam logic [79:0] VEC [0:9] = '{
    {16'd100,   16'd200,   16'd300,   8'd10,  8'd10,  8'd20,  8'd30 },
    {16'd15,    16'd25,    16'd35,    8'd10,  8'd2,   8'd3,   8'd4  },
    {16'd14,    16'd16,    16'd24,    8'd10,  8'd1,   8'd2,   8'd2  },
    {16'd7,     16'd0,     16'd65535, 8'd3,   8'd2,   8'd0,   8'd255},
    {16'd1000,  16'd999,   16'd2550,  8'd255, 8'd4,   8'd4,   8'd10 },
    {16'd5,     16'd0,     16'd9,     8'd0,   8'd0,   8'd0,   8'd0  },
    {16'd511,   16'd510,   16'd255,   8'd2,   8'd255, 8'd255, 8'd128},
    {16'd1,     16'd2,     16'd3,     8'd4,   8'd0,   8'd1,   8'd1  },
    {16'd65535, 16'd65534, 16'd40000, 8'd255, 8'd255, 8'd255, 8'd157},
    {16'd300,   16'd301,   16'd302,   8'd3,   8'd100, 8'd100, 8'd101}
  };

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] c, input logic [7:0] d,
                      input logic [7:0] er, input logic [7:0] eg,
                      input logic [7:0] eb, input string t);
    @(negedge clk);
    num_r = a; num_g = b; num_b = c; den = d; in_valid = 1'b1;
    exp_r[wr] = er; exp_g[wr] = eg; exp_b[wr] = eb;
    stamp[wr] = cyc; tag[wr] = t;
    wr++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: every valid result is matched in order, with its latency.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk("R7 R2 unexpected out_valid", 1, 0);
      end else begin
        chk({tag[rd], " red"},   int'(pix_r), int'(exp_r[rd]));
        chk({tag[rd], " green"}, int'(pix_g), int'(exp_g[rd]));
        chk({tag[rd], " blue"},  int'(pix_b), int'(exp_b[rd]));
        chk("R2 latency", cyc - stamp[rd], 9);
        rd++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    num_r = '0; num_g = '0; num_b = '0; den = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", int'(out_valid), 0);
    chk("R7 reset pix_r", int'(pix_r), 0);
    chk("R7 reset pix_b", int'(pix_b), 0);
    rst_n = 1'b1;
    idle(2);

    // Back-to-back table stream.
    for (int i = 0; i < 10; i++)
      push(VEC[i][79:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:24],
           VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R1 R3 R4 table");
    idle(14);
    chk("R3 table results all seen", rd, wr);

    // Single result, then outputs must hold.
    push(16'd40, 16'd50, 16'd60, 8'd7, 8'd6, 8'd7, 8'd9, "R8 single");
    idle(12);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 hold out_valid", int'(out_valid), 0);
      chk("R8 hold pix_r", int'(pix_r), 6);
      chk("R8 hold pix_g", int'(pix_g), 7);
      chk("R8 hold pix_b", int'(pix_b), 9);
    end

    // Directed corners.
    push(16'd65535, 16'd1, 16'd0, 8'd0, 8'd0, 8'd0, 8'd0, "R5 zero divisor");
    push(16'd300, 16'd256, 16'd255, 8'd1, 8'd255, 8'd255, 8'd255, "R6 clamp");
    push(16'd3, 16'd5, 16'd7, 8'd2, 8'd2, 8'd3, 8'd4, "R9 exact half");
    idle(12);
    chk("R5 R6 R9 results seen", rd, wr);

    // Reset with an operand set in flight: it must never emerge.
    @(negedge clk);
    num_r = 16'd100; num_g = 16'd100; num_b = 16'd100; den = 8'd1;
    in_valid = 1'b1;
    idle(3);
    rst_n = 1'b0;
    idle(2);
    chk("R7 pixels cleared by reset", int'(pix_g), 0);
    rst_n = 1'b1;
    idle(14);
    chk("R7 flushed out_valid", int'(out_valid), 0);
    chk("R7 flushed pix_r", int'(pix_r), 0);
    chk("R7 no stray result", rd, wr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule